// File: doc/BRIEF.md
# Key-Protected System Configuration Registers

This block is a small register bank on a simple synchronous register bus. It holds a 16-bit system configuration register with two live fields. One bit picks the branch target used when a debug exception is taken. A 3-bit field picks the size of the internal RAM. A key register guards the configuration register: a bus write to the configuration register lands only if the key register already holds the unlock byte 0x96 at that clock edge. With any other key value, the write is dropped silently.

The block also presents a read-only 32-bit register that reports where the debugger's 64-byte work area starts. It drives the decoded 24-bit debug-exception address and the RAM size code to the rest of the chip. A flag marks a size code that has no defined meaning. Some reserved bits of the configuration register read back as a fixed non-zero pattern that is set by a parameter. Addresses that hit no register read as zero. Register updates happen on the rising clock edge. Reset is synchronous and active high.

Top module: `cfgkey_regs`

## Requirements
- R1: Reset state: after a synchronous reset the key register reads 0x00, the debug select bit is 0 and the RAM size field holds the parameter SIZE_RST (default 0x1). The configuration register therefore starts locked.
- R2: A write to the configuration address (CFG_ADDR, default 1) loads bus_wdata[8] into the debug select bit and bus_wdata[2:0] into the RAM size field. This happens only if the key register held 0x96 before that rising edge. Otherwise the configuration register keeps its value.
- R3: The key register at KEY_ADDR (default 0) is an 8-bit read/write register. A write stores bus_wdata[7:0], and a read returns it in bus_rdata[7:0] with bits 31:8 zero.
- R4: A read of the configuration register returns the debug select bit in bit 8 and the RAM size code in bits 2:0. Bits 6:4 hold the parameter RSVD_HI (default 0x1). Bits 31:9, bit 7 and bit 3 are zero, whatever was written to them.
- R5: dbg_vector is 0xFFFC00 while the debug select bit is 0 and 0x000000 while it is 1.
- R6: ram_size_sel equals the stored RAM size code. ram_size_rsvd is 1 exactly when that code is not 0x1 (8KB), 0x2 (4KB) or 0x3 (2KB).
- R7: A read at BASE_ADDR (default 2) returns {8'h00, BASE_VAL}, with BASE_VAL defaulting to 24'h001FC0. Writes to that address change no register.
- R8: A read of any address other than KEY_ADDR, CFG_ADDR and BASE_ADDR returns 0. A write to such an address changes neither the key nor the configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dbg_vector | output | 24 | Debug-exception branch address |
| ram_size_sel | output | 3 | Current RAM size code |
| ram_size_rsvd | output | 1 | RAM size code is a reserved value |

## Verification
The hardest case to reach from the ports is the unlock window. A configuration write takes effect only when the key register already holds 0x96 at that edge. A key write and a configuration write issued back to back must therefore be seen in the right order. A key value one bit away from 0x96 must still leave the register locked. The stimulus sweeps all 256 key values, and after each key write it issues a configuration write whose data differs from the stored value. So only the single unlocking key shows a change. It then sweeps every select and size combination with the reserved bits set, while unlocked. It ends by writing to every other address and checking that nothing moved.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;

    localparam int          BUS_W      = 32;
    localparam int          CFG_W      = 16;
    localparam int          VEC_W      = 24;
    localparam int          KEY_W      = 8;
    localparam logic [7:0]  UNLOCK_KEY = 8'h96;
    localparam logic [23:0] VEC_HIGH   = 24'hFFFC00;
    localparam logic [23:0] VEC_ZERO   = 24'h000000;

    typedef enum logic [2:0] {
        SZ_8K = 3'd1,
        SZ_4K = 3'd2,
        SZ_2K = 3'd3
    } ram_size_e;

    typedef struct packed {
        logic       dbg_sel;
        logic [2:0] size;
    } cfg_t;

    function automatic logic size_is_rsvd(input logic [2:0] code);
        return !(code == SZ_8K || code == SZ_4K || code == SZ_2K);
    endfunction

    function automatic logic [VEC_W-1:0] dbg_target(input logic sel);
        return sel ? VEC_ZERO : VEC_HIGH;
    endfunction

    function automatic logic [CFG_W-1:0] pack_cfg(input cfg_t c, input logic [2:0] rsvd_hi);
        logic [CFG_W-1:0] w;
        w      = '0;
        w[8]   = c.dbg_sel;
        w[6:4] = rsvd_hi;
        w[2:0] = c.size;
        return w;
    endfunction

endpackage

// File: rtl/cfgkey_keyreg.sv
module cfgkey_keyreg
    import cfgkey_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wdata,
    output logic [KEY_W-1:0] key_q,
    output logic             unlocked
);

    always_ff @(posedge clk) begin
        if (rst)
            key_q <= '0;
        else if (wr_en)
            key_q <= wdata;
    end

    assign unlocked = (key_q == UNLOCK_KEY);

endmodule

// File: rtl/cfgkey_cfgreg.sv
module cfgkey_cfgreg
    import cfgkey_pkg::*;
#(
    parameter logic [2:0] SIZE_RST = 3'd1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wsel,
    input  logic [2:0] wsize,
    output cfg_t       cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.dbg_sel <= 1'b0;
            cfg_q.size    <= SIZE_RST;
        end else if (wr_en) begin
            cfg_q.dbg_sel <= wsel;
            cfg_q.size    <= wsize;
        end
    end

endmodule

// File: rtl/cfgkey_rdmux.sv
module cfgkey_rdmux
    import cfgkey_pkg::*;
#(
    parameter logic [2:0]  RSVD_HI  = 3'd1,
    parameter logic [23:0] BASE_VAL = 24'h001FC0
) (
    input  logic             hit_key,
    input  logic             hit_cfg,
    input  logic             hit_base,
    input  logic [KEY_W-1:0] key_q,
    input  cfg_t             cfg_q,
    output logic [BUS_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (hit_key)
            rdata[KEY_W-1:0] = key_q;
        else if (hit_cfg)
            rdata[CFG_W-1:0] = pack_cfg(cfg_q, RSVD_HI);
        else if (hit_base)
            rdata[VEC_W-1:0] = BASE_VAL;
    end

endmodule

// File: rtl/cfgkey_regs.sv
module cfgkey_regs
    import cfgkey_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'd0,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 4'd1,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 4'd2,
    parameter logic [2:0]        RSVD_HI   = 3'd1,
    parameter logic [2:0]        SIZE_RST  = 3'd1,
    parameter logic [23:0]       BASE_VAL  = 24'h001FC0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [23:0]       dbg_vector,
    output logic [2:0]        ram_size_sel,
    output logic              ram_size_rsvd
);

    logic             hit_key, hit_cfg, hit_base;
    logic             unlocked;
    logic [KEY_W-1:0] key_q;
    cfg_t             cfg_q;
    logic             unused_wbits;

    assign hit_key  = (bus_addr == KEY_ADDR);
    assign hit_cfg  = (bus_addr == CFG_ADDR);
    assign hit_base = (bus_addr == BASE_ADDR);

    assign unused_wbits = ^{bus_wdata[31:9], bus_wdata[7:3]};

    cfgkey_keyreg u_key (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr && hit_key),
        .wdata    (bus_wdata[KEY_W-1:0]),
        .key_q    (key_q),
        .unlocked (unlocked)
    );

    cfgkey_cfgreg #(.SIZE_RST(SIZE_RST)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr && hit_cfg && unlocked),
        .wsel  (bus_wdata[8]),
        .wsize (bus_wdata[2:0]),
        .cfg_q (cfg_q)
    );

    cfgkey_rdmux #(.RSVD_HI(RSVD_HI), .BASE_VAL(BASE_VAL)) u_rd (
        .hit_key  (hit_key),
        .hit_cfg  (hit_cfg),
        .hit_base (hit_base),
        .key_q    (key_q),
        .cfg_q    (cfg_q),
        .rdata    (bus_rdata)
    );

    assign dbg_vector    = dbg_target(cfg_q.dbg_sel);
    assign ram_size_sel  = cfg_q.size;
    assign ram_size_rsvd = size_is_rsvd(cfg_q.size);

endmodule

// File: rtl/cfgkey_regs_chk.sv
module cfgkey_regs_chk #(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'd0,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 4'd1,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 4'd2,
    parameter logic [23:0]       BASE_VAL  = 24'h001FC0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [23:0]       dbg_vector,
    input logic [2:0]        ram_size_sel,
    input logic              ram_size_rsvd,
    input logic [7:0]        key_q
);

    // R2
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == CFG_ADDR && key_q == 8'h96)
        |=> ($stable(ram_size_sel) && $stable(dbg_vector)));

    // R2
    unlocked_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == CFG_ADDR && key_q == 8'h96)
        |=> (ram_size_sel == $past(bus_wdata[2:0])));

    // R5
    vector_match_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == CFG_ADDR)
        |-> (dbg_vector == (bus_rdata[8] ? 24'h000000 : 24'hFFFC00)));

    // R6
    rsvd_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ram_size_rsvd |-> (ram_size_sel == 3'd0 || ram_size_sel > 3'd3));

    // R7
    base_const_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == BASE_ADDR) |-> (bus_rdata == {8'h00, BASE_VAL}));

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != KEY_ADDR && bus_addr != CFG_ADDR && bus_addr != BASE_ADDR)
        |-> (bus_rdata == 32'h0));

    // R3
    key_width_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == KEY_ADDR) |-> (bus_rdata[31:8] == 24'h0));

endmodule

bind cfgkey_regs cfgkey_regs_chk #(
    .ADDR_W    (ADDR_W),
    .KEY_ADDR  (KEY_ADDR),
    .CFG_ADDR  (CFG_ADDR),
    .BASE_ADDR (BASE_ADDR),
    .BASE_VAL  (BASE_VAL)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .dbg_vector    (dbg_vector),
    .ram_size_sel  (ram_size_sel),
    .ram_size_rsvd (ram_size_rsvd),
    .key_q         (key_q)
);

// File: tb/test_cfgkey_regs.sv
module test_cfgkey_regs;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0]  A_KEY  = 4'd0;
    localparam logic [3:0]  A_CFG  = 4'd1;
    localparam logic [3:0]  A_BASE = 4'd2;
    localparam logic [2:0]  RSV    = 3'd1;
    localparam logic [2:0]  SZRST  = 3'd1;
    localparam logic [23:0] BASEV  = 24'h001FC0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [23:0] dbg_vector;
    logic [2:0]  ram_size_sel;
    logic        ram_size_rsvd;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    logic       m_sel;
    logic [2:0] m_size;
    logic [7:0] m_key;

    cfgkey_regs i_cfgkey_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_vector(dbg_vector),
        .ram_size_sel(ram_size_sel), .ram_size_rsvd(ram_size_rsvd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_cfg(input logic s, input logic [2:0] z);
        return (32'(s) << 8) | (32'(RSV) << 4) | 32'(z);
    endfunction

    function automatic logic exp_rsvd(input logic [2:0] z);
        return (z == 3'd0) || (z > 3'd3);
    endfunction

    task automatic check_cfg(input string req);
        logic [31:0] d;
        rd(A_CFG, d);
        check(req, d, exp_cfg(m_sel, m_size));
        check("R5", 32'(dbg_vector), m_sel ? 32'h0 : 32'h00FFFC00);
        check("R6 sel", 32'(ram_size_sel), 32'(m_size));
        check("R6 flag", 32'(ram_size_rsvd), 32'(exp_rsvd(m_size)));
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_sel = 1'b0; m_size = SZRST; m_key = 8'h00;

        // R1 reset state
        rd(A_KEY, d);
        check("R1 key", d, 32'h0);
        check_cfg("R1 cfg");
        rd(A_BASE, d);
        check("R7 base", d, {8'h00, BASEV});

        // R2 / R3: sweep every key value, then try a config write
        for (int k = 0; k < 256; k++) begin
            logic       ns;
            logic [2:0] nz;
            ns = ~m_sel;
            nz = m_size + 3'd3;
            wr(A_KEY, {24'hA5C3E1, 8'(k)});
            m_key = 8'(k);
            rd(A_KEY, d);
            check("R3 key", d, {24'h0, m_key});
            wr(A_CFG, (32'(ns) << 8) | 32'(nz));
            if (m_key == 8'h96) begin
                m_sel = ns; m_size = nz;
            end
            check_cfg("R2 lock sweep");
        end

        // R4 / R5 / R6: all select/size combinations, reserved bits driven high
        wr(A_KEY, 32'h96);
        for (int v = 0; v < 16; v++) begin
            m_sel  = v[3];
            m_size = v[2:0];
            wr(A_CFG, 32'hFFFF_FEF8 | (32'(m_sel) << 8) | 32'(m_size));
            check_cfg("R4 layout");
        end

        // R2 back-to-back relock: key change then cfg write in next cycle
        wr(A_CFG, (32'h1 << 8) | 32'h2);
        m_sel = 1'b1; m_size = 3'd2;
        wr(A_KEY, 32'h97);
        wr(A_CFG, 32'h3);
        check_cfg("R2 relock");

        // R7: write to base while unlocked changes nothing
        wr(A_KEY, 32'h96);
        wr(A_BASE, 32'hFFFF_FFFF);
        rd(A_BASE, d);
        check("R7 base wr", d, {8'h00, BASEV});
        check_cfg("R7 cfg");

        // R8: every unmapped address reads 0 and ignores writes
        for (int a = 3; a < 16; a++) begin
            wr(4'(a), 32'hFFFF_FFFF);
            rd(4'(a), d);
            check("R8 read", d, 32'h0);
        end
        rd(A_KEY, d);
        check("R8 key", d, 32'h96);
        check_cfg("R8 cfg");

        // R1 again: reset mid-run relocks and restores defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_sel = 1'b0; m_size = SZRST;
        rd(A_KEY, d);
        check("R1 key2", d, 32'h0);
        check_cfg("R1 cfg2");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule